// File: doc/BRIEF.md
# Receive Flow-Control RTS Driver with Hysteresis

This block drives the active-low request-to-send line of a serial receiver from the fill count of its receive FIFO. Software picks one of four ascending trigger levels with a 2-bit select. The block raises a receive interrupt request whenever the fill count is at or above the selected level.

When automatic flow control is on and software has asserted RTS, the line stops the far end once the fill count reaches the level one step above the selected one. It lets data flow again only after the fill drops below the level one step beneath the selected one. The gap between those two thresholds keeps the line from chattering.

With automatic control off, the line is a plain software-driven output. The FIFO itself, the decoding of the configuration register and any modem-status logic sit outside this block.

Top module: `rts_hyst_ctrl`

## Requirements
- R1: While rst_ni is low, rts_n_o is 1 (deasserted) and rx_irq_o is 0.
- R2: With auto_en_i = 0, rts_n_o equals the inverse of rts_sw_i one clock after it is sampled; fill_i has no effect on it.
- R3: With auto_en_i = 1 and rts_sw_i = 0, rts_n_o is 1 one clock later, whatever the fill count.
- R4: rx_irq_o is 1 one clock after fill_i >= trigger level, and 0 one clock after fill_i < trigger level, independent of auto_en_i and rts_sw_i.
- R5: With auto_en_i = 1 and rts_sw_i = 1, rts_n_o becomes 1 one clock after fill_i >= the upper threshold. The upper threshold is the level one index above the selected one; for index 3 it is level 3 itself.
- R6: In the same mode, a stopped line returns to 0 one clock after fill_i < the lower threshold, or after fill_i == 0. The lower threshold is the level one index below the selected one; for index 0 it is zero. Between the two thresholds, rts_n_o keeps its previous value.
- R7: Clearing auto_en_i, or rts_sw_i, discards the stopped state. When both are later set with fill_i below the upper threshold, rts_n_o is 0 one clock later.
- R8: trig_sel_i values 0, 1, 2 and 3 select levels LVL0 < LVL1 < LVL2 < LVL3 in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fill_i | input | FILL_W | Receive FIFO occupancy |
| trig_sel_i | input | 2 | Trigger level index 0..3 |
| auto_en_i | input | 1 | Automatic RTS flow control enable |
| rts_sw_i | input | 1 | Software RTS request, 1 = assert |
| rts_n_o | output | 1 | RTS line, active low, registered |
| rx_irq_o | output | 1 | Receive trigger interrupt request, registered |

## Verification
Both outputs come from a single register stage, so every result is due exactly one rising edge after the inputs that cause it. The bench changes inputs on a falling edge and waits for the next rising edge. It compares at the falling edge that follows, against a model advanced once per step with the inputs that were applied. Each trigger index is swept with the fill count ramped fully up and then fully down, which crosses every threshold in both directions. The same holds for the manual mode and the enable-cleared case.

// File: rtl/rts_pkg.sv
package rts_pkg;
  localparam int unsigned NUM_LVL = 4;
  localparam int unsigned SEL_W   = $clog2(NUM_LVL);

  typedef enum logic [SEL_W-1:0] {
    TRIG_L0 = 2'd0,
    TRIG_L1 = 2'd1,
    TRIG_L2 = 2'd2,
    TRIG_L3 = 2'd3
  } trig_sel_e;
endpackage

// File: rtl/rts_thresh.sv
module rts_thresh
  import rts_pkg::*;
#(
  parameter int unsigned FILL_W = 8,
  parameter int unsigned LVL0   = 8,
  parameter int unsigned LVL1   = 16,
  parameter int unsigned LVL2   = 56,
  parameter int unsigned LVL3   = 60
) (
  input  logic [SEL_W-1:0]  sel_i,
  output logic [FILL_W-1:0] trig_o,
  output logic [FILL_W-1:0] upper_o,
  output logic [FILL_W-1:0] lower_o
);
  localparam int unsigned LVLS [NUM_LVL] = '{LVL0, LVL1, LVL2, LVL3};

  logic [FILL_W-1:0] trig_tab  [NUM_LVL];
  logic [FILL_W-1:0] upper_tab [NUM_LVL];
  logic [FILL_W-1:0] lower_tab [NUM_LVL];

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    assign trig_tab[g] = FILL_W'(LVLS[g]);
    if (g == NUM_LVL - 1) begin : g_top
      assign upper_tab[g] = FILL_W'(LVLS[g]);   // saturate at top level
    end else begin : g_up
      assign upper_tab[g] = FILL_W'(LVLS[g+1]);
    end
    if (g == 0) begin : g_bot
      assign lower_tab[g] = '0;
    end else begin : g_lo
      assign lower_tab[g] = FILL_W'(LVLS[g-1]);
    end
  end

  assign trig_o  = trig_tab[sel_i];
  assign upper_o = upper_tab[sel_i];
  assign lower_o = lower_tab[sel_i];
endmodule

// File: rtl/rts_hyst_core.sv
module rts_hyst_core #(
  parameter int unsigned FILL_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FILL_W-1:0] fill_i,
  input  logic [FILL_W-1:0] trig_i,
  input  logic [FILL_W-1:0] upper_i,
  input  logic [FILL_W-1:0] lower_i,
  input  logic              auto_en_i,
  input  logic              rts_sw_i,
  output logic              rts_n_o,
  output logic              rx_irq_o
);
  logic hold_q, hold_d;
  logic rts_n_q, rts_n_d;
  logic irq_q;
  logic armed, at_upper, below_lower;

  assign armed       = auto_en_i & rts_sw_i;
  assign at_upper    = fill_i >= upper_i;
  assign below_lower = (fill_i < lower_i) | (fill_i == '0);

  always_comb begin
    hold_d = hold_q;
    if (!armed)           hold_d = 1'b0;
    else if (at_upper)    hold_d = 1'b1;
    else if (below_lower) hold_d = 1'b0;
    rts_n_d = ~(rts_sw_i & ~(auto_en_i & hold_d));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= 1'b0;
      rts_n_q <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      rts_n_q <= rts_n_d;
      irq_q   <= fill_i >= trig_i;
    end
  end

  assign rts_n_o  = rts_n_q;
  assign rx_irq_o = irq_q;

  a_r2_manual_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_en_i |=> (rts_n_o == !$past(rts_sw_i)));
  a_r3_sw_off_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rts_sw_i |=> rts_n_o);
  a_r4_irq_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i >= trig_i) |=> rx_irq_o);
  a_r4_irq_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i < trig_i) |=> !rx_irq_o);
  a_r5_stop_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && at_upper) |=> rts_n_o);
  a_r6_keep_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && hold_q && !below_lower) |=> rts_n_o);
  a_r6_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && below_lower && !at_upper) |=> !rts_n_o);
  a_r7_fresh_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !hold_q && !at_upper) |=> !rts_n_o);
endmodule

// File: rtl/rts_hyst_ctrl.sv
module rts_hyst_ctrl
  import rts_pkg::*;
#(
  parameter int unsigned FILL_W = 8,
  parameter int unsigned LVL0   = 8,
  parameter int unsigned LVL1   = 16,
  parameter int unsigned LVL2   = 56,
  parameter int unsigned LVL3   = 60
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FILL_W-1:0] fill_i,
  input  logic [1:0]        trig_sel_i,
  input  logic              auto_en_i,
  input  logic              rts_sw_i,
  output logic              rts_n_o,
  output logic              rx_irq_o
);
  logic [FILL_W-1:0] trig, upper, lower;

  rts_thresh #(
    .FILL_W(FILL_W), .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3)
  ) thresh_i (
    .sel_i  (trig_sel_i),
    .trig_o (trig),
    .upper_o(upper),
    .lower_o(lower)
  );

  rts_hyst_core #(.FILL_W(FILL_W)) core_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fill_i   (fill_i),
    .trig_i   (trig),
    .upper_i  (upper),
    .lower_i  (lower),
    .auto_en_i(auto_en_i),
    .rts_sw_i (rts_sw_i),
    .rts_n_o  (rts_n_o),
    .rx_irq_o (rx_irq_o)
  );

  a_r8_levels_ordered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lower < upper) && (trig <= upper));
endmodule

// File: tb/rts_hyst_ctrl_tb_top.sv
module rts_hyst_ctrl_tb_top;
  localparam int FW = 5;
  localparam int L [4] = '{2, 5, 9, 14};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [FW-1:0] fill = '0;
  logic [1:0]    sel = '0;
  logic          en = 1'b0;
  logic          sw = 1'b0;
  logic          rts_n, irq;

  int checks = 0;
  int errors = 0;
  bit m_hold = 0;
  bit m_rts_n = 1;
  bit m_irq = 0;

  always #10 clk = ~clk;

  rts_hyst_ctrl #(
    .FILL_W(FW), .LVL0(2), .LVL1(5), .LVL2(9), .LVL3(14)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fill_i(fill), .trig_sel_i(sel),
    .auto_en_i(en), .rts_sw_i(sw), .rts_n_o(rts_n), .rx_irq_o(irq)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b (sel=%0d fill=%0d en=%0b sw=%0b)",
               tag, act, exp, sel, fill, en, sw);
    end
  endtask

  function automatic void model_step();
    int up, lo;
    up = (sel == 3) ? L[3] : L[sel+1];
    lo = (sel == 0) ? 0 : L[sel-1];
    if (!(en && sw))                 m_hold = 0;
    else if (fill >= up)             m_hold = 1;
    else if (fill < lo || fill == 0) m_hold = 0;
    m_rts_n = !(sw && !(en && m_hold));
    m_irq   = fill >= L[sel];
  endfunction

  task automatic step(input int f, input int s, input bit e, input bit w, input string tag);
    fill = FW'(f); sel = 2'(s); en = e; sw = w;
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(tag, rts_n, m_rts_n);
    chk("R4/R8 irq", irq, m_irq);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #25;
    chk("R1 rts_n reset", rts_n, 1'b1);
    chk("R1 irq reset", irq, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    // R2: manual mode, fill irrelevant
    for (int f = 0; f < 32; f++) step(f, f % 4, 0, f[0], "R2 manual");
    // R3: auto on, software not asserting
    for (int f = 31; f >= 0; f--) step(f, f % 4, 1, 0, "R3 sw off");

    // R5/R6/R8: full ramps per trigger index
    for (int s = 0; s < 4; s++) begin
      for (int f = 0; f < 32; f++) step(f, s, 1, 1, "R5 ramp up");
      for (int f = 31; f >= 0; f--) step(f, s, 1, 1, "R6 ramp down");
    end

    // R6: mid-band hold after stop, index 1 (lower 2, upper 9)
    step(10, 1, 1, 1, "R5 stop");
    chk("R5 stopped", rts_n, 1'b1);
    step(4, 1, 1, 1, "R6 hold band");
    chk("R6 still stopped", rts_n, 1'b1);
    step(1, 1, 1, 1, "R6 release");
    chk("R6 released", rts_n, 1'b0);

    // R7: clearing enable discards stop state
    step(12, 1, 1, 1, "R5 stop again");
    chk("R7 precondition", rts_n, 1'b1);
    step(12, 1, 0, 1, "R7 en cleared");
    chk("R7 manual low", rts_n, 1'b0);
    step(7, 1, 1, 1, "R7 re-armed");
    chk("R7 fresh arm low", rts_n, 1'b0);
    step(12, 3, 1, 1, "R5 top saturate");
    step(12, 3, 1, 0, "R7 sw cleared");
    step(7, 3, 1, 1, "R7 sw re-armed");
    chk("R7 fresh arm after sw", rts_n, 1'b0);

    // R1: reset mid-run
    @(negedge clk); rst_n = 1'b0;
    #3;
    chk("R1 rts_n async", rts_n, 1'b1);
    chk("R1 irq async", irq, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule